// File: doc/BRIEF.md
# Address-Routed Request Decoder

This block classifies one request header at a time and decides where the request goes, using only the address the header carries. Header doublewords arrive one per handshake on a 32-bit stream. A flag in the first doubleword selects a three-doubleword layout, which holds a 32-bit address, or a four-doubleword layout, which holds a 64-bit address. A type field in the first doubleword sorts the request into one of three groups: memory (plain and atomic), IO, or not address-routed.

The block first tests the extracted address against the port's own base address registers. Each register is given as a base, a size mask, an enable and a space flag (IO or memory). A hit means the request is consumed locally, and the lowest-numbered hitting register is reported. In switch mode, a request that misses every register is then tested against three inclusive base/limit windows. The IO window takes IO requests. The 32-bit non-prefetchable window and the 64-bit prefetchable window take memory requests. A window hit forwards the request downstream. Anything left over is an unsupported request. In endpoint mode the windows are never consulted.

The verdict is registered and is held until the consumer takes it. Register and window values are plain inputs.

Top module: `addr_route_decoder`

## Requirements
- R1: Bit 29 of the first doubleword set means a 4-doubleword header whose address is {DW2, DW3[31:2], 2'b00}. Clear means a 3-doubleword header whose address is {32'h0, DW2[31:2], 2'b00}. DW1 and the unused bits of DW0 have no effect.
- R2: The type field is DW0[28:24]. Codes 5'h00, 5'h01, 5'h0C, 5'h0D and 5'h0E are memory requests. 5'h02 is an IO request. Every other code yields verdict 3 (not address-routed) with index 0.
- R3: out_valid rises in the cycle after the handshake of the final header doubleword, and not earlier.
- R4: While out_valid is high and out_ready is low, the verdict and index stay unchanged, in_ready is low, and input doublewords are ignored. The cycle after out_ready is sampled high, out_valid is low.
- R5: A register i hits when all of the following hold: bar_en[i] is set, bar_io[i] equals "request is IO", and (addr & mask_i) == (base_i & mask_i). Any hit gives verdict 0 (local), and out_bar_idx is the hitting index.
- R6: When several registers hit, the lowest index is reported.
- R7: In switch mode (endpoint_mode low), if no register hits, the request is forwarded (verdict 1) when either of these holds: it is an IO request and io_base <= addr <= io_limit; or it is a memory request and addr lies inclusively within [np_base, np_limit] (zero-extended to 64 bits) or within [pf_base, pf_limit].
- R8: A window whose base exceeds its limit never hits. IO requests never hit the memory windows, and memory requests never hit the IO window.
- R9: An address-routed request that hits nothing yields verdict 2 (unsupported request), with index 0.
- R10: With endpoint_mode high, verdict 1 never occurs, and a register miss yields verdict 2.
- R11: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Header doubleword valid |
| in_ready | output | 1 | Decoder can take a doubleword |
| in_dw | input | 32 | Header doubleword |
| endpoint_mode | input | 1 | 1: register check only; 0: switch downstream port |
| bar_en | input | NUM_BARS | Per-register enable |
| bar_io | input | NUM_BARS | Per-register space flag, 1 = IO |
| bar_base | input | NUM_BARS*64 | Register bases, register i in bits [64i+63:64i] |
| bar_mask | input | NUM_BARS*64 | Register size masks, 1 = compared bit |
| io_base | input | 32 | IO window lower bound |
| io_limit | input | 32 | IO window upper bound |
| np_base | input | 32 | Non-prefetchable window lower bound |
| np_limit | input | 32 | Non-prefetchable window upper bound |
| pf_base | input | 64 | Prefetchable window lower bound |
| pf_limit | input | 64 | Prefetchable window upper bound |
| out_valid | output | 1 | Verdict available |
| out_ready | input | 1 | Consumer takes the verdict |
| out_verdict | output | 2 | 0 local, 1 forward, 2 unsupported, 3 not address-routed |
| out_bar_idx | output | IDX_W | Hitting register index when verdict is 0, else 0 |

## Verification
The assertions assume that register, window and mode inputs are steady from the start of a header until its verdict is taken, and that in_valid is not raised mid-header with a gap in which a new header starts. The bench meets this by changing configuration only between packets, when out_valid is low. It also always sends complete headers of the length that their own DW0 announces, and it uses 3-doubleword headers for IO requests and for addresses below 4 GB. The assertions further assume that out_ready may arrive at any time. The bench therefore holds it low for several cycles while driving garbage doublewords, then raises it.

// File: rtl/arw_pkg.sv
package arw_pkg;

  localparam int HDR_LONG_BIT = 29;
  localparam int TYPE_HI      = 28;
  localparam int TYPE_LO      = 24;

  typedef enum logic [1:0] {
    VERD_LOCAL = 2'd0,
    VERD_FWD   = 2'd1,
    VERD_UR    = 2'd2,
    VERD_SKIP  = 2'd3
  } verdict_e;

  typedef enum logic [1:0] {
    KIND_OTHER = 2'd0,
    KIND_MEM   = 2'd1,
    KIND_IO    = 2'd2
  } kind_e;

  function automatic kind_e classify_type(input logic [4:0] t);
    kind_e k;
    case (t)
      5'h00, 5'h01, 5'h0C, 5'h0D, 5'h0E: k = KIND_MEM;
      5'h02:                             k = KIND_IO;
      default:                           k = KIND_OTHER;
    endcase
    return k;
  endfunction

  function automatic logic bar_hit_f(input logic [63:0] a,
                                     input logic [63:0] base,
                                     input logic [63:0] mask);
    return (a & mask) == (base & mask);
  endfunction

  function automatic logic win_hit_f(input logic [63:0] a,
                                     input logic [63:0] lo,
                                     input logic [63:0] hi);
    return (lo <= hi) && (a >= lo) && (a <= hi);
  endfunction

endpackage

// File: rtl/arw_hdr_parser.sv
module arw_hdr_parser
  import arw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_ready,
  input  logic [31:0] in_dw,
  output logic        pkt_done,
  output logic [63:0] pkt_addr,
  output kind_e       pkt_kind
);

  logic [1:0]  idx_q;
  logic        long_q;
  kind_e       kind_q;
  logic [31:0] hi_q;
  logic        fire;
  logic        last_dw;
  logic        unused_bits;

  assign fire        = in_valid && in_ready;
  assign last_dw     = (idx_q != 2'd0) && (idx_q == (long_q ? 2'd3 : 2'd2));
  assign pkt_done    = fire && last_dw;
  assign pkt_kind    = kind_q;
  assign pkt_addr    = long_q ? {hi_q, in_dw[31:2], 2'b00}
                              : {32'h0, in_dw[31:2], 2'b00};
  assign unused_bits = ^{in_dw[31:30], in_dw[23:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= 2'd0;
      long_q <= 1'b0;
      kind_q <= KIND_OTHER;
      hi_q   <= 32'h0;
    end else if (fire) begin
      if (idx_q == 2'd0) begin
        long_q <= in_dw[HDR_LONG_BIT];
        kind_q <= classify_type(in_dw[TYPE_HI:TYPE_LO]);
        idx_q  <= 2'd1;
      end else if (last_dw) begin
        idx_q  <= 2'd0;
      end else begin
        idx_q  <= idx_q + 2'd1;
      end
      if (idx_q == 2'd2 && long_q) hi_q <= in_dw;
    end
  end

  // a short header never reaches the fourth doubleword slot
  assert_short_hdr_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(idx_q == 2'd3 && !long_q));

  // the slot counter returns to zero right after a completed header
  assert_idx_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> idx_q == 2'd0);

endmodule

// File: rtl/arw_bar_match.sv
module arw_bar_match
  import arw_pkg::*;
#(
  parameter int NUM_BARS = 6,
  parameter int IDX_W    = (NUM_BARS > 1) ? $clog2(NUM_BARS) : 1
) (
  input  logic [63:0]            addr,
  input  logic                   is_io,
  input  logic                   is_mem,
  input  logic [NUM_BARS-1:0]    en,
  input  logic [NUM_BARS-1:0]    io_space,
  input  logic [NUM_BARS*64-1:0] base_flat,
  input  logic [NUM_BARS*64-1:0] mask_flat,
  output logic                   any_hit,
  output logic [IDX_W-1:0]       hit_idx,
  output logic [NUM_BARS-1:0]    grant
);

  logic [NUM_BARS-1:0] hit_vec;

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
    logic space_ok;
    assign space_ok   = io_space[i] ? is_io : is_mem;
    assign hit_vec[i] = en[i] && space_ok &&
                        bar_hit_f(addr, base_flat[i*64 +: 64], mask_flat[i*64 +: 64]);
  end

  always_comb begin
    logic found;
    found   = 1'b0;
    grant   = '0;
    hit_idx = '0;
    for (int i = 0; i < NUM_BARS; i++) begin
      if (hit_vec[i] && !found) begin
        grant[i] = 1'b1;
        hit_idx  = IDX_W'(i);
        found    = 1'b1;
      end
    end
    any_hit = found;
  end

  always_comb begin
    if (any_hit) begin
      assert_grant_single_R6: assert ($onehot0(grant) && grant[hit_idx] && hit_vec[hit_idx]);
    end
  end

endmodule

// File: rtl/arw_window_match.sv
module arw_window_match
  import arw_pkg::*;
(
  input  logic [63:0] addr,
  input  logic        is_io,
  input  logic        is_mem,
  input  logic [31:0] io_base,
  input  logic [31:0] io_limit,
  input  logic [31:0] np_base,
  input  logic [31:0] np_limit,
  input  logic [63:0] pf_base,
  input  logic [63:0] pf_limit,
  output logic        win_hit,
  output logic        io_hit,
  output logic        mem_hit
);

  logic np_hit;
  logic pf_hit;

  assign io_hit  = is_io  && win_hit_f(addr, {32'h0, io_base}, {32'h0, io_limit});
  assign np_hit  = is_mem && win_hit_f(addr, {32'h0, np_base}, {32'h0, np_limit});
  assign pf_hit  = is_mem && win_hit_f(addr, pf_base, pf_limit);
  assign mem_hit = np_hit || pf_hit;
  assign win_hit = io_hit || mem_hit;

  always_comb begin
    assert_space_split_R8: assert (!(io_hit && mem_hit));
  end

endmodule

// File: rtl/addr_route_decoder.sv
module addr_route_decoder
  import arw_pkg::*;
#(
  parameter int NUM_BARS = 6,
  localparam int IDX_W   = (NUM_BARS > 1) ? $clog2(NUM_BARS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [31:0]            in_dw,
  input  logic                   endpoint_mode,
  input  logic [NUM_BARS-1:0]    bar_en,
  input  logic [NUM_BARS-1:0]    bar_io,
  input  logic [NUM_BARS*64-1:0] bar_base,
  input  logic [NUM_BARS*64-1:0] bar_mask,
  input  logic [31:0]            io_base,
  input  logic [31:0]            io_limit,
  input  logic [31:0]            np_base,
  input  logic [31:0]            np_limit,
  input  logic [63:0]            pf_base,
  input  logic [63:0]            pf_limit,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [1:0]             out_verdict,
  output logic [IDX_W-1:0]       out_bar_idx
);

  logic                pkt_done;
  logic [63:0]         pkt_addr;
  kind_e               pkt_kind;
  logic                is_io;
  logic                is_mem;
  logic                bar_any;
  logic [IDX_W-1:0]    bar_idx;
  logic [NUM_BARS-1:0] bar_grant;
  logic                win_hit;
  logic                win_io_hit;
  logic                win_mem_hit;
  verdict_e            dec_verdict;
  logic [IDX_W-1:0]    dec_idx;
  logic                take;

  assign in_ready = !out_valid;
  assign is_io    = (pkt_kind == KIND_IO);
  assign is_mem   = (pkt_kind == KIND_MEM);
  assign take     = out_valid && out_ready;

  arw_hdr_parser u_parser (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_dw    (in_dw),
    .pkt_done (pkt_done),
    .pkt_addr (pkt_addr),
    .pkt_kind (pkt_kind)
  );

  arw_bar_match #(.NUM_BARS(NUM_BARS), .IDX_W(IDX_W)) u_bars (
    .addr      (pkt_addr),
    .is_io     (is_io),
    .is_mem    (is_mem),
    .en        (bar_en),
    .io_space  (bar_io),
    .base_flat (bar_base),
    .mask_flat (bar_mask),
    .any_hit   (bar_any),
    .hit_idx   (bar_idx),
    .grant     (bar_grant)
  );

  arw_window_match u_windows (
    .addr     (pkt_addr),
    .is_io    (is_io),
    .is_mem   (is_mem),
    .io_base  (io_base),
    .io_limit (io_limit),
    .np_base  (np_base),
    .np_limit (np_limit),
    .pf_base  (pf_base),
    .pf_limit (pf_limit),
    .win_hit  (win_hit),
    .io_hit   (win_io_hit),
    .mem_hit  (win_mem_hit)
  );

  always_comb begin
    dec_idx = '0;
    if (pkt_kind == KIND_OTHER) begin
      dec_verdict = VERD_SKIP;
    end else if (bar_any) begin
      dec_verdict = VERD_LOCAL;
      dec_idx     = bar_idx;
    end else if (!endpoint_mode && win_hit) begin
      dec_verdict = VERD_FWD;
    end else begin
      dec_verdict = VERD_UR;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_verdict <= VERD_UR;
      out_bar_idx <= '0;
    end else if (pkt_done) begin
      out_valid   <= 1'b1;
      out_verdict <= dec_verdict;
      out_bar_idx <= dec_idx;
    end else if (take) begin
      out_valid   <= 1'b0;
    end
  end

  assert_rise_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> out_valid);

  assert_no_early_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !pkt_done) |=> !out_valid);

  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_verdict) && $stable(out_bar_idx)));

  assert_no_input_while_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_drop_after_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !out_valid);

  assert_local_needs_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && dec_verdict == VERD_LOCAL) |-> bar_grant[dec_idx]);

  assert_endpoint_no_fwd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && endpoint_mode) |-> dec_verdict != VERD_FWD);

  assert_fwd_needs_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && dec_verdict == VERD_FWD) |-> (win_io_hit || win_mem_hit) && !bar_any);

endmodule

// File: tb/addr_route_decoder_test.sv
`timescale 1ns/1ps
module addr_route_decoder_test;

  localparam int NB = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [31:0]   in_dw = '0;
  logic          endpoint_mode = 1'b0;
  logic [NB-1:0] bar_en;
  logic [NB-1:0] bar_io;
  logic [NB*64-1:0] bar_base;
  logic [NB*64-1:0] bar_mask;
  logic [31:0]   io_base, io_limit, np_base, np_limit;
  logic [63:0]   pf_base, pf_limit;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [1:0]    out_verdict;
  logic [2:0]    out_bar_idx;

  logic [63:0] bb [NB];
  logic [63:0] bm [NB];
  logic        ben [NB];
  logic        bio [NB];

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      bar_base[i*64 +: 64] = bb[i];
      bar_mask[i*64 +: 64] = bm[i];
      bar_en[i]            = ben[i];
      bar_io[i]            = bio[i];
    end
  end

  addr_route_decoder #(.NUM_BARS(NB)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_dw(in_dw),
    .endpoint_mode(endpoint_mode), .bar_en(bar_en), .bar_io(bar_io),
    .bar_base(bar_base), .bar_mask(bar_mask),
    .io_base(io_base), .io_limit(io_limit), .np_base(np_base), .np_limit(np_limit),
    .pf_base(pf_base), .pf_limit(pf_limit),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_verdict(out_verdict), .out_bar_idx(out_bar_idx)
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // kind: 0 not address-routed, 1 memory, 2 io
  function automatic logic [4:0] model(input logic [63:0] a, input int kind, input logic ep);
    if (kind == 0) return {2'd3, 3'd0};
    for (int i = 0; i < NB; i++) begin
      if (ben[i] && (bio[i] == (kind == 2)) && (((a ^ bb[i]) & bm[i]) == 64'h0))
        return {2'd0, 3'(i)};
    end
    if (!ep) begin
      if (kind == 2 && !(io_base > io_limit) && a >= {32'h0, io_base} && a <= {32'h0, io_limit})
        return {2'd1, 3'd0};
      if (kind == 1) begin
        if (!(np_base > np_limit) && a >= {32'h0, np_base} && a <= {32'h0, np_limit})
          return {2'd1, 3'd0};
        if (!(pf_base > pf_limit) && a >= pf_base && a <= pf_limit)
          return {2'd1, 3'd0};
      end
    end
    return {2'd2, 3'd0};
  endfunction

  function automatic int kind_of(input logic [4:0] t);
    if (t == 5'h00 || t == 5'h01 || t == 5'h0C || t == 5'h0D || t == 5'h0E) return 1;
    if (t == 5'h02) return 2;
    return 0;
  endfunction

  task automatic send(input logic long_hdr, input logic [4:0] typ, input logic [63:0] a,
                      input logic wr, input string req);
    logic [31:0] dws [4];
    int n;
    logic [4:0] e;
    n = long_hdr ? 4 : 3;
    dws[0] = {1'b0, wr, long_hdr, typ, 24'h5A5A01};
    dws[1] = 32'hBEEF_0F0F;
    if (long_hdr) begin
      dws[2] = a[63:32];
      dws[3] = {a[31:2], 2'b11};
    end else begin
      dws[2] = {a[31:2], 2'b10};
      dws[3] = 32'h0;
    end
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_dw    = dws[k];
      if (k == n - 1) chk(out_valid == 1'b0, "R3 early valid", out_valid, 0);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    e = model(a, kind_of(typ), endpoint_mode);
    chk(out_valid == 1'b1, "R3 valid after last", out_valid, 1);
    chk({out_verdict, out_bar_idx} == e, req, {out_verdict, out_bar_idx}, e);
    chk(in_ready == 1'b0, "R4 ready low while held", in_ready, 0);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid == 1'b0, "R4 valid drops after take", out_valid, 0);
  endtask

  task automatic sweep(input string tag);
    logic [63:0] addrs [20];
    addrs[0]  = 64'h0000_0000_1000_0000;
    addrs[1]  = 64'h0000_0000_100F_FFFC;
    addrs[2]  = 64'h0000_0000_1010_0000;
    addrs[3]  = 64'h0000_0000_0000_2000;
    addrs[4]  = 64'h0000_0000_0000_20FC;
    addrs[5]  = 64'h0000_0000_0000_2100;
    addrs[6]  = 64'h0000_0000_0000_4000;
    addrs[7]  = 64'h0000_0000_0000_4FFC;
    addrs[8]  = 64'h0000_0000_0000_5000;
    addrs[9]  = 64'h0000_0000_8000_0000;
    addrs[10] = 64'h0000_0000_8FFF_FFFC;
    addrs[11] = 64'h0000_0000_9000_0000;
    addrs[12] = 64'h0000_0001_2000_0000;
    addrs[13] = 64'h0000_0001_2001_0000;
    addrs[14] = 64'h0000_0002_0000_0000;
    addrs[15] = 64'h0000_0002_FFFF_FFFC;
    addrs[16] = 64'h0000_0003_0000_0000;
    addrs[17] = 64'h0000_0000_0000_3FFC;
    addrs[18] = 64'h0000_0001_1000_0000;
    addrs[19] = 64'h0000_0000_0000_7FFC;
    for (int ep = 0; ep < 2; ep++) begin
      endpoint_mode = ep[0];
      for (int j = 0; j < 20; j++) begin
        send(1'b1, 5'h00, addrs[j], j[0], {tag, " R1 R5 R7 R9 R10 mem long"});
        send(1'b1, 5'h0D, addrs[j], 1'b1, {tag, " R2 R6 R8 atomic long"});
        if (addrs[j][63:32] == 32'h0) begin
          send(1'b0, 5'h00, addrs[j], 1'b0, {tag, " R1 R5 R6 mem short"});
          send(1'b0, 5'h02, addrs[j], j[1], {tag, " R2 R7 R8 io short"});
          send(1'b0, 5'h04, addrs[j], 1'b0, {tag, " R2 not address-routed"});
        end
      end
    end
    endpoint_mode = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // BAR0 memory 1 MB, BAR1 disabled (overlaps BAR0), BAR2 IO 256 B,
    // BAR3 memory 64 KB above 4 GB, BAR4 memory 16 MB overlapping BAR0, BAR5 IO 4 KB
    bb[0] = 64'h0000_0000_1000_0000; bm[0] = 64'hFFFF_FFFF_FFF0_0000; ben[0] = 1; bio[0] = 0;
    bb[1] = 64'h0000_0000_1000_0000; bm[1] = 64'hFFFF_FFFF_FFF0_0000; ben[1] = 0; bio[1] = 0;
    bb[2] = 64'h0000_0000_0000_2000; bm[2] = 64'hFFFF_FFFF_FFFF_FF00; ben[2] = 1; bio[2] = 1;
    bb[3] = 64'h0000_0001_2000_0000; bm[3] = 64'hFFFF_FFFF_FFFF_0000; ben[3] = 1; bio[3] = 0;
    bb[4] = 64'h0000_0000_1000_0000; bm[4] = 64'hFFFF_FFFF_FF00_0000; ben[4] = 1; bio[4] = 0;
    bb[5] = 64'h0000_0000_0000_3000; bm[5] = 64'hFFFF_FFFF_FFFF_F000; ben[5] = 1; bio[5] = 1;
    io_base  = 32'h0000_4000; io_limit = 32'h0000_4FFC;
    np_base  = 32'h8000_0000; np_limit = 32'h8FFF_FFFC;
    pf_base  = 64'h0000_0002_0000_0000; pf_limit = 64'h0000_0002_FFFF_FFFC;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R11 reset out_valid", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R11 out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R11 in_ready after reset", in_ready, 1);

    sweep("pass-normal");

    // R8: reversed windows are disabled
    np_base = 32'h9000_0000; np_limit = 32'h8000_0000;
    pf_base = 64'h0000_0003_0000_0000; pf_limit = 64'h0000_0002_0000_0000;
    io_base = 32'h0000_5000; io_limit = 32'h0000_4000;
    sweep("pass-reversed R8");
    io_base  = 32'h0000_4000; io_limit = 32'h0000_4FFC;
    np_base  = 32'h8000_0000; np_limit = 32'h8FFF_FFFC;
    pf_base  = 64'h0000_0002_0000_0000; pf_limit = 64'h0000_0002_FFFF_FFFC;

    // R4: hold under backpressure, ignore garbage input
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_dw = (k == 0) ? {3'b001, 5'h00, 24'h0} : ((k == 1) ? 32'h1 : 32'h0);
    end
    @(negedge clk);
    in_dw = 32'h0000_4000;
    @(negedge clk);
    chk(out_valid == 1'b1 && out_verdict == 2'd2, "R4 held verdict present", {out_valid, out_verdict}, 3'b110);
    for (int k = 0; k < 4; k++) begin
      in_dw = {3'b001, 5'h02, 24'h0} ^ 32'(k);
      @(negedge clk);
      chk(out_valid == 1'b1 && out_verdict == 2'd2 && out_bar_idx == 3'd0,
          "R4 verdict stable under backpressure", {out_valid, out_verdict}, 3'b110);
      chk(in_ready == 1'b0, "R4 in_ready low under backpressure", in_ready, 0);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid == 1'b0, "R4 released", out_valid, 0);
    send(1'b0, 5'h02, 64'h0000_0000_0000_4000, 1'b0, "R4 parser unaffected by ignored words R7");
    send(1'b0, 5'h01, 64'h0000_0000_1000_0010, 1'b0, "R6 lowest of BAR0 and BAR4");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule